// File: doc/BRIEF.md
# Dual-Bus Parallel Word Transfer Unit

This block carries out paired 16-bit data moves for a DSP register file. Each command can hold one X-memory operation and one Y-memory operation, and both run in the same cycle over separate address, data and enable ports. Neither side ever waits for the other.

Loads and stores are fixed to sides. An X-side load lands in one of two X data registers, and a Y-side load lands in one of two Y data registers. A store on either side takes its data from one of two accumulator inputs. Only the upper half of a 32-bit register takes part in a transfer. A store sends out bits [31:16] of the source. A load writes the memory word into bits [31:16] of the destination and clears bits [15:0].

A decoder upstream presents one command per cycle, qualified by a valid strobe. Both memories return read data one cycle after they see the address. Commands may follow each other on every cycle.

Top module: `dual_word_mover`

## Requirements
- R1: When one command carries an operation on both sides, the X port and the Y port are both enabled in that same cycle, and each drives its own command address (`x_mem_addr` = `x_addr`, `y_mem_addr` = `y_addr`).
- R2: An X load (operation code 2'b01) writes only X register 0 (select 0) or X register 1 (select 1). No other register changes.
- R3: A Y load (operation code 2'b01) writes only Y register 0 (select 0) or Y register 1 (select 1). No other register changes.
- R4: A store (operation code 2'b10) raises write-enable and keeps read-enable low in the command cycle. The write data is bits [31:16] of `acc0` (select 0) or `acc1` (select 1).
- R5: After a load, the destination holds the memory word in bits [31:16] and zero in bits [15:0].
- R6: Read data is taken in the cycle after the load command, and the destination register changes at the end of that cycle. `done` is high during that cycle for every command that had a load or store on at least one side.
- R7: Operation code 2'b00 (none) and operation code 2'b11 (illegal) raise no enable on that side, change no register and do not, on their own, cause `done`.
- R8: When both sides load in one command, both destination registers update on the same clock edge.
- R9: After reset, all four data registers read zero, and `done` and every memory enable are low.
- R10: While `cmd_valid` is low, no memory enable is raised, whatever the operation fields hold.
- R11: When a side is not storing, its write-data port is driven to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| x_op | input | 2 | X operation: 00 none, 01 load, 10 store, 11 treated as none |
| x_sel | input | 1 | X register / accumulator select |
| x_addr | input | 16 | X word address |
| y_op | input | 2 | Y operation, same encoding as x_op |
| y_sel | input | 1 | Y register / accumulator select |
| y_addr | input | 16 | Y word address |
| acc0 | input | 32 | Accumulator 0, store source |
| acc1 | input | 32 | Accumulator 1, store source |
| x_mem_addr | output | 16 | X memory address |
| x_mem_wdata | output | 16 | X memory write data |
| x_mem_we | output | 1 | X memory write enable |
| x_mem_re | output | 1 | X memory read enable |
| x_mem_rdata | input | 16 | X memory read data, one cycle after the address |
| y_mem_addr | output | 16 | Y memory address |
| y_mem_wdata | output | 16 | Y memory write data |
| y_mem_we | output | 1 | Y memory write enable |
| y_mem_re | output | 1 | Y memory read enable |
| y_mem_rdata | input | 16 | Y memory read data, one cycle after the address |
| done | output | 1 | Transfer completion pulse |
| xreg0 | output | 32 | X data register 0 |
| xreg1 | output | 32 | X data register 1 |
| yreg0 | output | 32 | Y data register 0 |
| yreg1 | output | 32 | Y data register 1 |

## Verification
The memory-port outputs (enables, address and store data) follow the command in the same cycle. The bench samples them 1 ns after it drives the command, at the falling edge. `done` is due one cycle after the command, and the bench compares it with a one-deep queue of issued commands. A load's register result becomes visible two cycles after the command, so the bench keeps a two-deep queue and applies its model update only when the second falling edge arrives. All four registers are then compared in full, which also shows a write to the wrong side or the wrong select.

// File: rtl/dual_word_mover_pkg.sv
package dual_word_mover_pkg;
  localparam int WORD_W = 16;
  localparam int REG_W  = 2 * WORD_W;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_BAD   = 2'b11
  } xfer_op_e;

  // Upper half of a register: the half that travels on a word bus.
  function automatic logic [WORD_W-1:0] hi_word(input logic [REG_W-1:0] r);
    return r[REG_W-1 -: WORD_W];
  endfunction

  // Register image produced by a load: word on top, zeros below.
  function automatic logic [REG_W-1:0] load_image(input logic [WORD_W-1:0] w);
    return {w, {WORD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/dwm_lane.sv
module dwm_lane
  import dual_word_mover_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [1:0]        op,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  src0,
  input  logic [REG_W-1:0]  src1,
  input  logic [WORD_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              issue,
  output logic              fire,
  output logic              fire_sel,
  output logic [WORD_W-1:0] fire_word
);
  logic is_load, is_store;
  logic pend_q, pend_sel_q;

  assign is_load  = valid && (op == OP_LOAD);
  assign is_store = valid && (op == OP_STORE);
  assign issue    = is_load || is_store;

  assign mem_addr  = addr;
  assign mem_we    = is_store;
  assign mem_re    = is_load;
  assign mem_wdata = is_store ? hi_word(sel ? src1 : src0) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_sel_q <= 1'b0;
    end else begin
      pend_q     <= is_load;
      pend_sel_q <= sel;
    end
  end

  assign fire      = pend_q;
  assign fire_sel  = pend_sel_q;
  assign fire_word = rdata;
endmodule

// File: rtl/dwm_regpair.sv
module dwm_regpair
  import dual_word_mover_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              wsel,
  input  logic [WORD_W-1:0] wword,
  output logic [REG_W-1:0]  r0,
  output logic [REG_W-1:0]  r1
);
  logic [REG_W-1:0] regs_q [2];

  for (genvar i = 0; i < 2; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[i] <= '0;
      else if (wr && (wsel == i[0]))
        regs_q[i] <= load_image(wword);
    end
  end

  assign r0 = regs_q[0];
  assign r1 = regs_q[1];
endmodule

// File: rtl/dual_word_mover.sv
module dual_word_mover
  import dual_word_mover_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        x_op,
  input  logic              x_sel,
  input  logic [ADDR_W-1:0] x_addr,
  input  logic [1:0]        y_op,
  input  logic              y_sel,
  input  logic [ADDR_W-1:0] y_addr,
  input  logic [31:0]       acc0,
  input  logic [31:0]       acc1,
  output logic [ADDR_W-1:0] x_mem_addr,
  output logic [15:0]       x_mem_wdata,
  output logic              x_mem_we,
  output logic              x_mem_re,
  input  logic [15:0]       x_mem_rdata,
  output logic [ADDR_W-1:0] y_mem_addr,
  output logic [15:0]       y_mem_wdata,
  output logic              y_mem_we,
  output logic              y_mem_re,
  input  logic [15:0]       y_mem_rdata,
  output logic              done,
  output logic [31:0]       xreg0,
  output logic [31:0]       xreg1,
  output logic [31:0]       yreg0,
  output logic [31:0]       yreg1
);
  // Named internal events, visible to the bound checker.
  logic x_issue, y_issue;
  logic x_fire, y_fire;
  logic x_fire_sel, y_fire_sel;
  logic [WORD_W-1:0] x_fire_word, y_fire_word;
  logic done_q;

  dwm_lane #(.ADDR_W(ADDR_W)) u_xlane (
    .clk(clk), .rst_n(rst_n), .valid(cmd_valid), .op(x_op), .sel(x_sel),
    .addr(x_addr), .src0(acc0), .src1(acc1), .rdata(x_mem_rdata),
    .mem_addr(x_mem_addr), .mem_wdata(x_mem_wdata), .mem_we(x_mem_we),
    .mem_re(x_mem_re), .issue(x_issue), .fire(x_fire),
    .fire_sel(x_fire_sel), .fire_word(x_fire_word)
  );

  dwm_lane #(.ADDR_W(ADDR_W)) u_ylane (
    .clk(clk), .rst_n(rst_n), .valid(cmd_valid), .op(y_op), .sel(y_sel),
    .addr(y_addr), .src0(acc0), .src1(acc1), .rdata(y_mem_rdata),
    .mem_addr(y_mem_addr), .mem_wdata(y_mem_wdata), .mem_we(y_mem_we),
    .mem_re(y_mem_re), .issue(y_issue), .fire(y_fire),
    .fire_sel(y_fire_sel), .fire_word(y_fire_word)
  );

  dwm_regpair u_xregs (
    .clk(clk), .rst_n(rst_n), .wr(x_fire), .wsel(x_fire_sel),
    .wword(x_fire_word), .r0(xreg0), .r1(xreg1)
  );

  dwm_regpair u_yregs (
    .clk(clk), .rst_n(rst_n), .wr(y_fire), .wsel(y_fire_sel),
    .wword(y_fire_word), .r0(yreg0), .r1(yreg1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= x_issue || y_issue;
  end

  assign done = done_q;
endmodule

// File: rtl/dual_word_mover_chk.sv
module dual_word_mover_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        x_op,
  input logic [ADDR_W-1:0] x_addr,
  input logic [1:0]        y_op,
  input logic [ADDR_W-1:0] y_addr,
  input logic [ADDR_W-1:0] x_mem_addr,
  input logic [ADDR_W-1:0] y_mem_addr,
  input logic              x_mem_we,
  input logic              x_mem_re,
  input logic              y_mem_we,
  input logic              y_mem_re,
  input logic [15:0]       x_mem_rdata,
  input logic [15:0]       y_mem_rdata,
  input logic              done,
  input logic              x_fire,
  input logic              x_fire_sel,
  input logic              y_fire,
  input logic              y_fire_sel,
  input logic [31:0]       xreg0,
  input logic [31:0]       xreg1,
  input logic [31:0]       yreg0,
  input logic [31:0]       yreg1
);
  assert_parallel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && x_op == 2'b01 && y_op == 2'b01) |->
      (x_mem_re && y_mem_re && x_mem_addr == x_addr && y_mem_addr == y_addr));

  assert_xload_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (x_fire && !x_fire_sel) |=> (xreg0 == {$past(x_mem_rdata), 16'h0}));

  assert_yload_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (y_fire && y_fire_sel) |=> (yreg1 == {$past(y_mem_rdata), 16'h0}));

  assert_we_re_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(x_mem_we && x_mem_re) && !(y_mem_we && y_mem_re));

  assert_low_half_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    x_fire |=> (xreg0[15:0] == 16'h0 && xreg1[15:0] == 16'h0));

  assert_load_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && x_op == 2'b01) |=> (x_fire && done));

  assert_illegal_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (x_op == 2'b11) |-> (!x_mem_we && !x_mem_re));

  assert_dual_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && x_op == 2'b01 && y_op == 2'b01) |=> (x_fire && y_fire));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (!x_mem_we && !x_mem_re && !y_mem_we && !y_mem_re));
endmodule

bind dual_word_mover dual_word_mover_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
  .x_op(x_op), .x_addr(x_addr), .y_op(y_op), .y_addr(y_addr),
  .x_mem_addr(x_mem_addr), .y_mem_addr(y_mem_addr),
  .x_mem_we(x_mem_we), .x_mem_re(x_mem_re),
  .y_mem_we(y_mem_we), .y_mem_re(y_mem_re),
  .x_mem_rdata(x_mem_rdata), .y_mem_rdata(y_mem_rdata),
  .done(done), .x_fire(x_fire), .x_fire_sel(x_fire_sel),
  .y_fire(y_fire), .y_fire_sel(y_fire_sel),
  .xreg0(xreg0), .xreg1(xreg1), .yreg0(yreg0), .yreg1(yreg1)
);

// File: tb/dual_word_mover_test.sv
`timescale 1ns/1ps
module dual_word_mover_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] x_op = 2'b00, y_op = 2'b00;
  logic x_sel = 1'b0, y_sel = 1'b0;
  logic [15:0] x_addr = '0, y_addr = '0;
  logic [31:0] acc0 = '0, acc1 = '0;
  logic [15:0] x_mem_addr, y_mem_addr, x_mem_wdata, y_mem_wdata;
  logic x_mem_we, x_mem_re, y_mem_we, y_mem_re;
  logic [15:0] x_mem_rdata = '0, y_mem_rdata = '0;
  logic done;
  logic [31:0] xreg0, xreg1, yreg0, yreg1;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dual_word_mover uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .x_op(x_op), .x_sel(x_sel), .x_addr(x_addr),
    .y_op(y_op), .y_sel(y_sel), .y_addr(y_addr),
    .acc0(acc0), .acc1(acc1),
    .x_mem_addr(x_mem_addr), .x_mem_wdata(x_mem_wdata),
    .x_mem_we(x_mem_we), .x_mem_re(x_mem_re), .x_mem_rdata(x_mem_rdata),
    .y_mem_addr(y_mem_addr), .y_mem_wdata(y_mem_wdata),
    .y_mem_we(y_mem_we), .y_mem_re(y_mem_re), .y_mem_rdata(y_mem_rdata),
    .done(done), .xreg0(xreg0), .xreg1(xreg1), .yreg0(yreg0), .yreg1(yreg1)
  );

  // Memory environment: 256 words per side, one-cycle read latency.
  logic [15:0] xmem [256];
  logic [15:0] ymem [256];
  always @(posedge clk) begin
    if (x_mem_we) xmem[x_mem_addr[7:0]] <= x_mem_wdata;
    if (x_mem_re) x_mem_rdata <= xmem[x_mem_addr[7:0]];
    if (y_mem_we) ymem[y_mem_addr[7:0]] <= y_mem_wdata;
    if (y_mem_re) y_mem_rdata <= ymem[y_mem_addr[7:0]];
  end

  // Reference register model and pipeline of pending effects.
  logic [31:0] mx [2];
  logic [31:0] my [2];
  logic p1_any = 0, p1_xl = 0, p1_yl = 0, p1_xs = 0, p1_ys = 0;
  logic [15:0] p1_xw = 0, p1_yw = 0;
  logic p2_xl = 0, p2_yl = 0, p2_xs = 0, p2_ys = 0;
  logic [15:0] p2_xw = 0, p2_yw = 0;

  function automatic logic [31:0] ld_img(input logic [15:0] w);
    logic [31:0] r;
    r[31:16] = w;
    r[15:0] = 16'h0000;
    return r;
  endfunction

  function automatic logic [15:0] st_word(input logic s, input logic [31:0] a0,
                                          input logic [31:0] a1);
    logic [31:0] a;
    a = s ? a1 : a0;
    return a[31:16];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One command cycle: check results due now, then drive and check ports.
  task automatic step(input logic v, input logic [1:0] xo, input logic xs,
                      input logic [15:0] xa, input logic [1:0] yo, input logic ys,
                      input logic [15:0] ya, input logic [31:0] a0, input logic [31:0] a1);
    logic xl, yl, xst, yst;
    @(negedge clk);
    // register results of the command two cycles back (R2 R3 R5 R8)
    if (p2_xl) mx[p2_xs] = ld_img(p2_xw);
    if (p2_yl) my[p2_ys] = ld_img(p2_yw);
    chk("R2 R5 xreg0", xreg0, mx[0]);
    chk("R2 R5 xreg1", xreg1, mx[1]);
    chk("R3 R8 yreg0", yreg0, my[0]);
    chk("R3 R8 yreg1", yreg1, my[1]);
    chk("R6 R7 done", {31'b0, done}, {31'b0, p1_any});
    p2_xl = p1_xl; p2_yl = p1_yl; p2_xs = p1_xs; p2_ys = p1_ys;
    p2_xw = p1_xw; p2_yw = p1_yw;
    cmd_valid = v; x_op = xo; x_sel = xs; x_addr = xa;
    y_op = yo; y_sel = ys; y_addr = ya; acc0 = a0; acc1 = a1;
    #1;
    xl = v && xo == 2'b01; xst = v && xo == 2'b10;
    yl = v && yo == 2'b01; yst = v && yo == 2'b10;
    chk("R7 R10 x_mem_re", {31'b0, x_mem_re}, {31'b0, xl});
    chk("R4 R7 R10 x_mem_we", {31'b0, x_mem_we}, {31'b0, xst});
    chk("R7 R10 y_mem_re", {31'b0, y_mem_re}, {31'b0, yl});
    chk("R4 R7 R10 y_mem_we", {31'b0, y_mem_we}, {31'b0, yst});
    chk("R4 R11 x_mem_wdata", {16'h0, x_mem_wdata}, {16'h0, xst ? st_word(xs, a0, a1) : 16'h0});
    chk("R4 R11 y_mem_wdata", {16'h0, y_mem_wdata}, {16'h0, yst ? st_word(ys, a0, a1) : 16'h0});
    if (xl || xst) chk("R1 x_mem_addr", {16'h0, x_mem_addr}, {16'h0, xa});
    if (yl || yst) chk("R1 y_mem_addr", {16'h0, y_mem_addr}, {16'h0, ya});
    p1_any = xl || xst || yl || yst;
    p1_xl = xl; p1_yl = yl; p1_xs = xs; p1_ys = ys;
    p1_xw = xmem[xa[7:0]]; p1_yw = ymem[ya[7:0]];
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 256; i++) begin
      xmem[i] = 16'hA000 ^ (16'(i) * 16'd37);
      ymem[i] = 16'h5000 ^ (16'(i) * 16'd91);
    end
    mx[0] = '0; mx[1] = '0; my[0] = '0; my[1] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9 regs", xreg0 | xreg1 | yreg0 | yreg1, 32'h0);
    chk("R9 done", {31'b0, done}, 32'h0);
    chk("R9 enables", {28'b0, x_mem_we, x_mem_re, y_mem_we, y_mem_re}, 32'h0);
    rst_n = 1'b1;
    // directed: dual load into both select-1 registers (R8, R1)
    step(1, 2'b01, 1, 16'h0011, 2'b01, 1, 16'h0022, 32'h1234_5678, 32'h9ABC_DEF0);
    // directed: stores from both accumulators, lower halves nonzero (R4)
    step(1, 2'b10, 0, 16'h0030, 2'b10, 1, 16'h0031, 32'hBEEF_FFFF, 32'hCAFE_FFFF);
    // directed: illegal code both sides (R7)
    step(1, 2'b11, 0, 16'h0030, 2'b11, 0, 16'h0031, 32'h1111_2222, 32'h3333_4444);
    // directed: reload stored words (R5)
    step(1, 2'b01, 0, 16'h0030, 2'b01, 0, 16'h0031, 32'h0, 32'h0);
    // directed: valid low with ops present (R10)
    step(0, 2'b01, 1, 16'h0005, 2'b10, 1, 16'h0006, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // directed: X only, Y none (R2)
    step(1, 2'b01, 0, 16'h0007, 2'b00, 0, 16'h0000, 32'h0, 32'h0);
    step(1, 2'b00, 0, 16'h0000, 2'b01, 0, 16'h0008, 32'h0, 32'h0);
    for (int n = 0; n < 400; n++) begin
      step(($urandom % 8) != 0, 2'($urandom), 1'($urandom), 16'($urandom % 64),
           2'($urandom), 1'($urandom), 16'($urandom % 64), $urandom, $urandom);
    end
    repeat (3) step(0, 2'b00, 0, 16'h0, 2'b00, 0, 16'h0, 32'h0, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule